// File: doc/BRIEF.md
# Transceiver Startup Lock Sequencer

This controller walks a serial transceiver through its power-on stages on a reference clock of known frequency. A prescaler turns reference cycles into a microsecond count. The sequencer state uses that count to step through four timed windows:

1. The PLL is held at its lowest frequency while bias settles.
2. The PLL and the receiver analog loops are allowed to lock.
3. The receiver locks onto incoming data.
4. A guard interval runs before received data is declared valid.

Each stage drives its own enable strobes. The current stage is also visible on a 3-bit status output.

The sequencer stays in the held stage under any of these conditions:

- the power-on reset is high;
- a hard reset has been accepted;
- the PLL is bypassed.

A hard reset is accepted only after it has been high for a minimum width. Shorter pulses are discarded.

After data is valid, pulling the active-low reference-lock request low parks the receiver in an idle stage. Releasing the request starts a short relock window, after which valid data returns.

A sleep request powers the PLL down and emits a periodic refresh enable from a divided reference clock. Leaving sleep replays the complete timed startup.

The states are named by their stage value:

| Value | State | Meaning |
|---|---|---|
| 0 | HELD | held |
| 1 | BIAS | bias settle |
| 2 | PLL | PLL lock |
| 3 | RXLOCK | data lock |
| 4 | GUARD | guard |
| 5 | VALID | data valid |
| 6 | IDLE | receiver idle |
| 7 | SLEEP | sleep |

The transitions are:

- **HELD→BIAS**: all blockers are low.
- **BIAS→PLL**: at 32 µs.
- **PLL→RXLOCK**: at 262 µs.
- **RXLOCK→GUARD**: at 326 µs.
- **GUARD→VALID**: at 358 µs.
- **VALID→IDLE**: the lock request goes low.
- **IDLE→VALID**: the relock window expires.
- **any→SLEEP**: the sleep request is high and no blocker is active.
- **SLEEP→BIAS**: the sleep request is released.
- **any→HELD**: a blocker is active. Blockers take priority over sleep.

Top module: `xcvr_lock_seq`

## Requirements
- R1: While `pwr_on_rst`, an accepted hard reset or `pll_bypass` is active, the next edge puts `stage` at 0 (HELD). In HELD, `pll_hold_min`, `phase_rst` and `lpf_rst` are 1 and every other strobe is 0.
- R2: When all blockers and `sleep_req` are low in HELD, the next edge enters stage 1 (BIAS). BIAS lasts exactly 32×CYC_PER_US cycles, with only `pll_hold_min` high. Data becomes valid 1+358×CYC_PER_US edges after the blockers drop.
- R3: Stage 2 (PLL) spans cycles 32×CYC_PER_US to 262×CYC_PER_US after BIAS entry, with `pll_lock_en` and `rx_analog_en` high.
- R4: Stage 3 (RXLOCK) spans cycles 262×CYC_PER_US to 326×CYC_PER_US, adding `data_lock_en` to the stage 2 strobes.
- R5: Stage 4 (GUARD) spans cycles 326×CYC_PER_US to 358×CYC_PER_US, with the same strobes as stage 3 and `data_valid` low.
- R6: From cycle 358×CYC_PER_US the sequencer is in stage 5 (VALID) with `data_valid` high. `comma_align_en` equals `comma_en` in the same cycle while in VALID and is 0 in every other stage.
- R7: `ref_lock_n` low in VALID moves the sequencer to stage 6 (IDLE) on the next edge, with `data_valid` low and the lock strobes of stage 3 kept. `ref_lock_n` low in any earlier stage has no effect.
- R8: In IDLE, after `ref_lock_n` has been high for 2×CYC_PER_US consecutive edges, the sequencer returns to VALID. A low sample restarts that window.
- R9: `hard_rst` is accepted on the edge where it has been high for RST_MIN_US×CYC_PER_US consecutive cycles, and the sequencer stays HELD while it remains high. A shorter pulse leaves the stage unchanged.
- R10: With no blocker active, `sleep_req` high moves any stage to stage 7 (SLEEP) on the next edge. In SLEEP, `pll_pwr_dn` is 1 and all other strobes are 0.
- R11: In SLEEP, `refresh_en` is high for one cycle in every REFRESH_DIV cycles, on SLEEP cycle indices REFRESH_DIV−1, 2×REFRESH_DIV−1, and so on (index 0 is the first SLEEP cycle). It is 0 outside SLEEP.
- R12: Releasing `sleep_req` enters BIAS with a cleared timer, so data becomes valid 1+358×CYC_PER_US edges later.
- R13: A blocker overrides `sleep_req`: with both active the stage is HELD, and removing only the blocker returns the sequencer to SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_on_rst | input | 1 | Power-on reset, active high, synchronous |
| hard_rst | input | 1 | Hard reset request, active high, minimum-width qualified |
| pll_bypass | input | 1 | PLL bypass; holds the sequencer in HELD |
| sleep_req | input | 1 | Low-power request |
| ref_lock_n | input | 1 | Lock-to-reference request, active low |
| comma_en | input | 1 | Enables comma alignment once data is valid |
| pll_hold_min | output | 1 | Holds the PLL at minimum frequency |
| pll_lock_en | output | 1 | Allows the PLL to lock |
| rx_analog_en | output | 1 | Enables receiver analog lock |
| data_lock_en | output | 1 | Enables lock onto incoming data |
| data_valid | output | 1 | Received data is valid |
| comma_align_en | output | 1 | Comma alignment enable |
| phase_rst | output | 1 | Resets the phase selection |
| lpf_rst | output | 1 | Resets the receive loop filter |
| pll_pwr_dn | output | 1 | PLL power down |
| refresh_en | output | 1 | Divided refresh clock enable in sleep |
| stage | output | 3 | Current stage value (0 to 7) |

## Verification
The startup is run three times, each from a different entry: after a bypass release, after a qualified hard reset, and after leaving sleep. This shows that every entry clears the microsecond timer, and it measures the exact edge count to valid data.

Hard-reset pulses of one cycle below the minimum width and of exactly the minimum width separate "ignored" from "accepted". A lock-request pulse during PLL lock, compared with one in VALID, shows that the idle path opens only after data is valid. An interrupted release in IDLE shows that the relock window restarts.

Bypass and sleep applied together confirm the priority of the blockers. Counting refresh pulses confirms the divider phase.

// File: rtl/xcvr_seq_pkg.sv
package xcvr_seq_pkg;

    typedef enum logic [2:0] {
        ST_HELD   = 3'd0,
        ST_BIAS   = 3'd1,
        ST_PLL    = 3'd2,
        ST_RXLOCK = 3'd3,
        ST_GUARD  = 3'd4,
        ST_VALID  = 3'd5,
        ST_IDLE   = 3'd6,
        ST_SLEEP  = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic hold_min;
        logic lock_en;
        logic rx_analog;
        logic data_lock;
        logic valid;
        logic phase_rst;
        logic lpf_rst;
        logic pwr_dn;
    } strobe_t;

endpackage

// File: rtl/xcvr_us_timer.sv
module xcvr_us_timer #(
    parameter int CYC_PER_US = 125,
    parameter int US_MAX     = 358,
    localparam int PRE_W     = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1,
    localparam int US_W      = $clog2(US_MAX + 1)
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            clr,
    output logic            tick,
    output logic [US_W-1:0] us_cnt
);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;

    assign tick   = (pre_q == PRE_W'(CYC_PER_US - 1));
    assign us_cnt = us_q;

    always_ff @(posedge clk) begin
        if (srst || clr) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            us_q  <= us_q + US_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // The sequencer clears the count before it can pass its last window.
    assert_us_bound_R5: assert property (@(posedge clk) disable iff (srst)
        us_q <= US_W'(US_MAX));

endmodule

// File: rtl/xcvr_rst_qual.sv
module xcvr_rst_qual #(
    parameter int MIN_CYC = 125,
    localparam int CW     = $clog2(MIN_CYC + 1)
) (
    input  logic clk,
    input  logic srst,
    input  logic hard_rst,
    output logic accepted
);

    logic [CW-1:0] run_q;

    assign accepted = hard_rst && (run_q >= CW'(MIN_CYC - 1));

    always_ff @(posedge clk) begin
        if (srst || !hard_rst) begin
            run_q <= '0;
        end else if (run_q != CW'(MIN_CYC)) begin
            run_q <= run_q + CW'(1);
        end
    end

    generate
        if (MIN_CYC > 1) begin : g_width_chk
            assert_min_width_R9: assert property (@(posedge clk) disable iff (srst)
                accepted |-> $past(hard_rst));
        end
    endgenerate

endmodule

// File: rtl/xcvr_refresh_div.sv
module xcvr_refresh_div #(
    parameter int DIV  = 8,
    localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic srst,
    input  logic run,
    output logic pulse
);

    logic [DW-1:0] div_q;

    assign pulse = run && (div_q == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (srst || !run || pulse) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assert_refresh_gated_R11: assert property (@(posedge clk) disable iff (srst)
        !run |=> (div_q == '0));

endmodule

// File: rtl/xcvr_lock_seq.sv
module xcvr_lock_seq
    import xcvr_seq_pkg::*;
#(
    parameter int CYC_PER_US  = 125,
    parameter int RST_MIN_US  = 1,
    parameter int REFRESH_DIV = 8,
    parameter int T_BIAS_US   = 32,
    parameter int T_PLL_US    = 262,
    parameter int T_RX_US     = 326,
    parameter int T_GUARD_US  = 358,
    parameter int T_RELOCK_US = 2
) (
    input  logic       clk,
    input  logic       pwr_on_rst,
    input  logic       hard_rst,
    input  logic       pll_bypass,
    input  logic       sleep_req,
    input  logic       ref_lock_n,
    input  logic       comma_en,
    output logic       pll_hold_min,
    output logic       pll_lock_en,
    output logic       rx_analog_en,
    output logic       data_lock_en,
    output logic       data_valid,
    output logic       comma_align_en,
    output logic       phase_rst,
    output logic       lpf_rst,
    output logic       pll_pwr_dn,
    output logic       refresh_en,
    output logic [2:0] stage
);

    localparam int US_W    = $clog2(T_GUARD_US + 1);
    localparam int RST_CYC = RST_MIN_US * CYC_PER_US;

    seq_state_t      state_q, state_d;
    strobe_t         strb;
    logic            rst_acc;
    logic            blocked;
    logic            tick;
    logic            timer_clr;
    logic [US_W-1:0] us_cnt;

    xcvr_rst_qual #(.MIN_CYC(RST_CYC)) u_rst_qual (
        .clk      (clk),
        .srst     (pwr_on_rst),
        .hard_rst (hard_rst),
        .accepted (rst_acc)
    );

    xcvr_us_timer #(.CYC_PER_US(CYC_PER_US), .US_MAX(T_GUARD_US)) u_timer (
        .clk    (clk),
        .srst   (pwr_on_rst),
        .clr    (timer_clr),
        .tick   (tick),
        .us_cnt (us_cnt)
    );

    xcvr_refresh_div #(.DIV(REFRESH_DIV)) u_refresh (
        .clk   (clk),
        .srst  (pwr_on_rst),
        .run   (state_q == ST_SLEEP),
        .pulse (refresh_en)
    );

    assign blocked = pwr_on_rst || rst_acc || pll_bypass;

    // Timer runs only through the timed windows and the relock window.
    assign timer_clr = (state_q == ST_HELD) || (state_q == ST_SLEEP) ||
                       (state_q == ST_VALID) ||
                       ((state_q == ST_IDLE) && !ref_lock_n);

    // State register
    always_ff @(posedge clk) begin
        if (pwr_on_rst) begin
            state_q <= ST_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (blocked) begin
            state_d = ST_HELD;
        end else if (sleep_req) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_HELD:   state_d = ST_BIAS;
                ST_SLEEP:  state_d = ST_BIAS;
                ST_BIAS:   if (tick && us_cnt == US_W'(T_BIAS_US - 1))   state_d = ST_PLL;
                ST_PLL:    if (tick && us_cnt == US_W'(T_PLL_US - 1))    state_d = ST_RXLOCK;
                ST_RXLOCK: if (tick && us_cnt == US_W'(T_RX_US - 1))     state_d = ST_GUARD;
                ST_GUARD:  if (tick && us_cnt == US_W'(T_GUARD_US - 1))  state_d = ST_VALID;
                ST_VALID:  if (!ref_lock_n)                              state_d = ST_IDLE;
                ST_IDLE:   if (ref_lock_n && tick &&
                               us_cnt == US_W'(T_RELOCK_US - 1))         state_d = ST_VALID;
                default:   state_d = ST_HELD;
            endcase
        end
    end

    // Stage strobes
    always_comb begin
        strb = '0;
        unique case (state_q)
            ST_HELD: begin
                strb.hold_min  = 1'b1;
                strb.phase_rst = 1'b1;
                strb.lpf_rst   = 1'b1;
            end
            ST_BIAS: strb.hold_min = 1'b1;
            ST_PLL: begin
                strb.lock_en   = 1'b1;
                strb.rx_analog = 1'b1;
            end
            ST_RXLOCK, ST_GUARD, ST_IDLE: begin
                strb.lock_en   = 1'b1;
                strb.rx_analog = 1'b1;
                strb.data_lock = 1'b1;
            end
            ST_VALID: begin
                strb.lock_en   = 1'b1;
                strb.rx_analog = 1'b1;
                strb.data_lock = 1'b1;
                strb.valid     = 1'b1;
            end
            ST_SLEEP: strb.pwr_dn = 1'b1;
            default:  strb = '0;
        endcase
    end

    assign pll_hold_min   = strb.hold_min;
    assign pll_lock_en    = strb.lock_en;
    assign rx_analog_en   = strb.rx_analog;
    assign data_lock_en   = strb.data_lock;
    assign data_valid     = strb.valid;
    assign phase_rst      = strb.phase_rst;
    assign lpf_rst        = strb.lpf_rst;
    assign pll_pwr_dn     = strb.pwr_dn;
    assign comma_align_en = strb.valid && comma_en;
    assign stage          = state_q;

    assert_pll_mode_excl_R3: assert property (@(posedge clk) disable iff (pwr_on_rst)
        $onehot0({pll_hold_min, pll_lock_en, pll_pwr_dn}));

    assert_bias_window_R2: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (state_q == ST_PLL && $past(state_q) == ST_BIAS) |->
            ($past(us_cnt) == US_W'(T_BIAS_US - 1) && $past(tick)));

    assert_valid_entry_R5: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (state_q == ST_VALID && $past(state_q) != ST_VALID) |->
            ($past(state_q) == ST_GUARD || $past(state_q) == ST_IDLE));

    assert_idle_entry_R7: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |->
            ($past(state_q) == ST_VALID && !$past(ref_lock_n)));

    assert_comma_gate_R6: assert property (@(posedge clk) disable iff (pwr_on_rst)
        comma_align_en |-> data_valid);

    assert_refresh_in_sleep_R11: assert property (@(posedge clk) disable iff (pwr_on_rst)
        refresh_en |-> pll_pwr_dn);

    assert_reset_held_R9: assert property (@(posedge clk) disable iff (pwr_on_rst)
        rst_acc |=> (state_q == ST_HELD));

    assert_blocker_over_sleep_R13: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (pll_bypass && sleep_req) |=> (state_q == ST_HELD));

endmodule

// File: tb/test_xcvr_lock_seq.sv
`timescale 1ns/1ps
module test_xcvr_lock_seq;

    localparam int C    = 4;
    localparam int RMIN = 1;
    localparam int DIV  = 4;
    localparam int MINR = C * RMIN;

    logic clk = 1'b0;
    logic pwr_on_rst, hard_rst, pll_bypass, sleep_req, ref_lock_n, comma_en;
    logic pll_hold_min, pll_lock_en, rx_analog_en, data_lock_en, data_valid;
    logic comma_align_en, phase_rst, lpf_rst, pll_pwr_dn, refresh_en;
    logic [2:0] stage;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    xcvr_lock_seq #(
        .CYC_PER_US(C), .RST_MIN_US(RMIN), .REFRESH_DIV(DIV)
    ) i_xcvr_lock_seq (
        .clk(clk), .pwr_on_rst(pwr_on_rst), .hard_rst(hard_rst),
        .pll_bypass(pll_bypass), .sleep_req(sleep_req), .ref_lock_n(ref_lock_n),
        .comma_en(comma_en), .pll_hold_min(pll_hold_min), .pll_lock_en(pll_lock_en),
        .rx_analog_en(rx_analog_en), .data_lock_en(data_lock_en),
        .data_valid(data_valid), .comma_align_en(comma_align_en),
        .phase_rst(phase_rst), .lpf_rst(lpf_rst), .pll_pwr_dn(pll_pwr_dn),
        .refresh_en(refresh_en), .stage(stage)
    );

    always #2 clk = ~clk;

    // Behavioural reference model
    int m_state = 0;
    int m_el    = 0;
    int m_run   = 0;
    int m_div   = 0;

    always @(posedge clk) begin
        automatic bit acc = hard_rst && (m_run >= MINR - 1);
        automatic int prev = m_state;
        if (pwr_on_rst) begin
            m_state = 0; m_el = 0; m_run = 0; m_div = 0;
        end else begin
            m_run = hard_rst ? ((m_run + 1 > MINR) ? MINR : m_run + 1) : 0;
            m_div = (prev == 7) ? ((m_div + 1) % DIV) : 0;
            if (acc || pll_bypass) begin
                m_state = 0; m_el = 0;
            end else if (sleep_req) begin
                m_state = 7; m_el = 0;
            end else if (prev == 0 || prev == 7) begin
                m_state = 1; m_el = 0;
            end else if (prev >= 1 && prev <= 4) begin
                m_el++;
                if      (m_el >= 358 * C) begin m_state = 5; m_el = 0; end
                else if (m_el >= 326 * C) m_state = 4;
                else if (m_el >= 262 * C) m_state = 3;
                else if (m_el >= 32 * C)  m_state = 2;
            end else if (prev == 5) begin
                if (!ref_lock_n) begin m_state = 6; m_el = 0; end
            end else begin
                if (!ref_lock_n) m_el = 0;
                else begin
                    m_el++;
                    if (m_el >= 2 * C) begin m_state = 5; m_el = 0; end
                end
            end
        end
    end

    function automatic string req_of(int s);
        case (s)
            0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
            4: return "R5";  5: return "R6";  6: return "R8";  default: return "R10";
        endcase
    endfunction

    function automatic logic [10:0] exp_vec(int s);
        logic [10:0] v;
        v = '0;
        v[10:8] = 3'(s);
        case (s)
            0: begin v[7] = 1; v[2] = 1; v[1] = 1; end
            1: v[7] = 1;
            2: begin v[6] = 1; v[5] = 1; end
            3, 4, 6: begin v[6] = 1; v[5] = 1; v[4] = 1; end
            5: begin v[6] = 1; v[5] = 1; v[4] = 1; v[3] = 1; end
            default: v[0] = 1;
        endcase
        return v;
    endfunction

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        begin
            automatic logic [10:0] act = {stage, pll_hold_min, pll_lock_en, rx_analog_en,
                                          data_lock_en, data_valid, phase_rst, lpf_rst,
                                          pll_pwr_dn};
            automatic logic [10:0] exp = exp_vec(m_state);
            automatic logic exp_ca = (m_state == 5) && comma_en;
            automatic logic exp_rf = (m_state == 7) && (m_div == DIV - 1);
            n_checks++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s stage/strobes cycle %0d actual %b expected %b",
                         req_of(m_state), cyc, act, exp);
            end
            n_checks++;
            if (comma_align_en !== exp_ca) begin
                n_fail++;
                $display("FAIL R6 comma_align_en cycle %0d actual %b expected %b",
                         cyc, comma_align_en, exp_ca);
            end
            n_checks++;
            if (refresh_en !== exp_rf) begin
                n_fail++;
                $display("FAIL R11 refresh_en cycle %0d actual %b expected %b",
                         cyc, refresh_en, exp_rf);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic steps(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges_to_valid(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!data_valid && n < 5000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
            finish_run();
        end
    end

    initial begin
        int n;
        pwr_on_rst = 1; hard_rst = 0; pll_bypass = 1; sleep_req = 0;
        ref_lock_n = 1; comma_en = 0;
        steps(5);
        chk("R1 held stage under power-on reset", stage, 0);
        chk("R1 phase_rst in held stage", phase_rst, 1);
        pwr_on_rst = 0;
        steps(10);
        chk("R1 bypass keeps held stage", stage, 0);

        // R2..R6: full startup from bypass release
        pll_bypass = 0;
        edges_to_valid(n);
        chk("R2 startup length to data valid", n, 1 + 358 * C);
        @(negedge clk); comma_en = 1;
        @(posedge clk); #1;
        chk("R6 comma_align_en follows comma_en in VALID", comma_align_en, 1);
        @(negedge clk); comma_en = 0;

        // R7/R8: idle and relock
        ref_lock_n = 0;
        @(posedge clk); #1;
        chk("R7 lock request enters IDLE", stage, 6);
        chk("R7 data_valid low in IDLE", data_valid, 0);
        steps(5);
        ref_lock_n = 1; steps(3);
        ref_lock_n = 0; steps(2);
        chk("R8 interrupted release stays IDLE", stage, 6);
        ref_lock_n = 1;
        edges_to_valid(n);
        chk("R8 relock window length", n, 2 * C);

        // R9: short pulse ignored, full pulse accepted
        @(negedge clk); hard_rst = 1;
        steps(MINR - 1); hard_rst = 0;
        steps(2);
        chk("R9 short hard reset ignored", stage, 5);
        hard_rst = 1;
        steps(MINR);
        chk("R9 qualified hard reset holds", stage, 0);
        steps(3);
        chk("R9 held while reset stays high", stage, 0);
        hard_rst = 0;

        // R7: early lock request ignored
        steps(40 * C);
        ref_lock_n = 0; steps(10);
        chk("R7 lock request before VALID ignored", stage, 2);
        ref_lock_n = 1;
        while (stage != 3) @(negedge clk);

        // R10/R11: sleep
        sleep_req = 1;
        @(posedge clk); #1;
        chk("R10 sleep entered", stage, 7);
        chk("R10 PLL powered down", pll_pwr_dn, 1);
        n = 0;
        repeat (4 * DIV) begin
            @(posedge clk); #1;
            if (refresh_en) n++;
        end
        chk("R11 refresh pulse count", n, 4);

        // R13: blocker over sleep
        @(negedge clk); pll_bypass = 1;
        @(posedge clk); #1;
        chk("R13 bypass overrides sleep", stage, 0);
        @(negedge clk); pll_bypass = 0;
        @(posedge clk); #1;
        chk("R13 back to sleep", stage, 7);

        // R12: full timing after sleep exit
        @(negedge clk); sleep_req = 0;
        edges_to_valid(n);
        chk("R12 full startup after sleep", n, 1 + 358 * C);
        steps(5);
        finish_run();
    end

endmodule